// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel flash interface. It watches accepted bus write cycles and turns them into launch requests for the array engine. There are four kinds of request: word program, sector erase, block erase and whole-chip erase. A request is launched only when a guarded write sequence arrives in full. Every command opens with a two-write unlock pair. Erase commands need a second unlock pair after the erase setup code.

The block also keeps an identification mode. While that mode is set, reads of word addresses 0 and 1 return fixed identifier words. A busy input from the status logic blocks all command decoding while an internal operation runs. A write-protect input shields the topmost blocks of the array from program and erase.

Each launch is a single-cycle pulse. It comes with the target address, already aligned to the erase granule, and with the program data. The array storage and the operation timing sit outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command is only recognised after an unlock pair: low byte AAh written at command address 5555h, then low byte 55h at command address 2AAAh. A setup code with no unlock launches nothing.
- R2: After unlock, A0h at 5555h arms a program. The next accepted write gives the target. `go_prog` then pulses in the cycle after that write, with `op_addr`/`op_data` equal to that write's full address and data.
- R3: After unlock, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 30h at any address pulses `go_sect_erase`. `op_addr` is that address with bits 9..0 cleared (1 Kword sectors).
- R4: The same six-write preamble ending in 50h pulses `go_blk_erase`. `op_addr` is the address with bits 14..0 cleared (32 Kword blocks).
- R5: The six-write preamble ending in 10h at 5555h pulses `go_chip_erase` with `op_addr` 0. `skip_top` equals 1 if write-protect was asserted (wp_n low) on the final write, else 0.
- R6: After unlock, 90h at 5555h sets `id_mode` and F0h at 5555h clears it. While `id_mode` is 1, `rd_addr` 0 gives `id_data` 00BFh and `rd_addr` 1 gives 2762h, both with `id_valid` 1. Any other read address, or `id_mode` 0, gives `id_valid` 0 and `id_data` 0.
- R7: In command cycles only address bits 14..0 and data bits 7..0 are compared. Address bits 19..15 and data bits 15..8 take no part.
- R8: A write that does not match the expected step abandons the sequence and returns to the idle step. That write itself is not taken as a new unlock start.
- R9: While `busy` is 1, write strobes are ignored entirely. The sequence step and `id_mode` are left unchanged, and this includes an ID-exit sequence.
- R10: With wp_n low, a program, sector erase or block erase whose address lies in blocks 28..31 (address bits 19..15 at or above 28) gives no launch pulse, and the decoder returns to idle.
- R11: Reset (rst_n low, asynchronous) returns the decoder to idle, clears `id_mode` and drops all launch outputs.
- R12: Launch pulses last exactly one cycle, and at most one of the four launch outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Internal operation in progress |
| wp_n | input | 1 | Write protect, active low |
| rd_addr | input | 20 | Read word address for identifier lookup |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 16 | Identifier word for `rd_addr` |
| id_valid | output | 1 | `id_data` holds an identifier |
| go_prog | output | 1 | Word-program launch pulse |
| go_sect_erase | output | 1 | Sector-erase launch pulse |
| go_blk_erase | output | 1 | Block-erase launch pulse |
| go_chip_erase | output | 1 | Chip-erase launch pulse |
| skip_top | output | 1 | With chip erase: leave protected blocks untouched |
| op_addr | output | 20 | Target address of the launch |
| op_data | output | 16 | Program data of the launch |

## Verification
The bound checker covers the rules that hold on every cycle:
- the launch outputs are one-hot and last one cycle;
- no launch appears unless an accepted, non-busy write came before it;
- `id_mode` holds steady and nothing launches while busy;
- a protected launch never escapes while wp_n is low;
- `skip_top` agrees with write-protect;
- identifiers show only in ID mode.

The exact command grammar can only be shown by the bench's scripted sequences: unlock ordering, abort on a wrong step, ignored upper bits, erase address alignment and the identifier values. So can the fact that a busy-blocked write leaves a half-entered sequence intact for the next one.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Sequence steps of the command decoder
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UNLK1  = 3'd1,
        ST_UNLK2  = 3'd2,
        ST_PROG   = 3'd3,
        ST_ERS1   = 3'd4,
        ST_ERS2   = 3'd5,
        ST_ERS3   = 3'd6
    } seq_e;

    typedef enum logic [2:0] {
        LN_NONE = 3'd0,
        LN_PROG = 3'd1,
        LN_SECT = 3'd2,
        LN_BLK  = 3'd3,
        LN_CHIP = 3'd4
    } launch_e;

    // Low-byte command codes
    localparam logic [7:0] CD_UNLK_A  = 8'hAA;
    localparam logic [7:0] CD_UNLK_B  = 8'h55;
    localparam logic [7:0] CD_PROG    = 8'hA0;
    localparam logic [7:0] CD_ERS_SET = 8'h80;
    localparam logic [7:0] CD_ID_IN   = 8'h90;
    localparam logic [7:0] CD_ID_OUT  = 8'hF0;
    localparam logic [7:0] CD_SECT    = 8'h30;
    localparam logic [7:0] CD_BLK     = 8'h50;
    localparam logic [7:0] CD_CHIP    = 8'h10;

    typedef struct packed {
        seq_e    seq;
        logic    id_mode;
        launch_e launch;
        logic    skip_top;
    } ctl_s;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match #(
    parameter int unsigned CMD_AW = 15,
    parameter logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA
) (
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_code,
    output logic              at_key_a,
    output logic              at_key_b,
    output logic              is_unlk_a,
    output logic              is_unlk_b,
    output logic              is_prog,
    output logic              is_ers_set,
    output logic              is_id_in,
    output logic              is_id_out,
    output logic              is_sect,
    output logic              is_blk,
    output logic              is_chip
);
    import flash_cmd_pkg::*;

    always_comb begin
        at_key_a   = (cmd_addr == KEY_ADDR_A);
        at_key_b   = (cmd_addr == KEY_ADDR_B);
        is_unlk_a  = (cmd_code == CD_UNLK_A);
        is_unlk_b  = (cmd_code == CD_UNLK_B);
        is_prog    = (cmd_code == CD_PROG);
        is_ers_set = (cmd_code == CD_ERS_SET);
        is_id_in   = (cmd_code == CD_ID_IN);
        is_id_out  = (cmd_code == CD_ID_OUT);
        is_sect    = (cmd_code == CD_SECT);
        is_blk     = (cmd_code == CD_BLK);
        is_chip    = (cmd_code == CD_CHIP);
    end

endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check #(
    parameter int unsigned BLK_IDX_W  = 5,
    parameter int unsigned PROT_COUNT = 4
) (
    input  logic [BLK_IDX_W-1:0] blk_idx,
    input  logic                 wp_n,
    output logic                 locked
);
    localparam int unsigned NUM_BLK = 1 << BLK_IDX_W;
    localparam logic [BLK_IDX_W-1:0] FIRST_PROT = BLK_IDX_W'(NUM_BLK - PROT_COUNT);

    always_comb begin
        locked = !wp_n && (blk_idx >= FIRST_PROT);
    end

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16,
    parameter logic [DW-1:0] ID_WORD0 = 16'h00BF,
    parameter logic [DW-1:0] ID_WORD1 = 16'h2762
) (
    input  logic          id_mode,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] id_data,
    output logic          id_valid
);
    always_comb begin
        id_valid = id_mode && (rd_addr[AW-1:1] == '0);
        id_data  = '0;
        if (id_valid) begin
            id_data = rd_addr[0] ? ID_WORD1 : ID_WORD0;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int unsigned AW         = 20,
    parameter int unsigned DW         = 16,
    parameter int unsigned CMD_AW     = 15,
    parameter int unsigned SECT_LSB   = 10,
    parameter int unsigned BLK_LSB    = 15,
    parameter int unsigned PROT_COUNT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          wp_n,
    input  logic [AW-1:0] rd_addr,
    output logic          id_mode,
    output logic [DW-1:0] id_data,
    output logic          id_valid,
    output logic          go_prog,
    output logic          go_sect_erase,
    output logic          go_blk_erase,
    output logic          go_chip_erase,
    output logic          skip_top,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    import flash_cmd_pkg::*;

    localparam int unsigned BLK_IDX_W = AW - BLK_LSB;

    logic at_a, at_b;
    logic c_ua, c_ub, c_prog, c_eset, c_idin, c_idout, c_sect, c_blk, c_chip;
    logic locked;
    logic accept;

    ctl_s          ctl_d, ctl_q;
    logic [AW-1:0] op_addr_d, op_addr_q;
    logic [DW-1:0] op_data_d, op_data_q;

    flash_cmd_match #(
        .CMD_AW     (CMD_AW),
        .KEY_ADDR_A (CMD_AW'(15'h5555)),
        .KEY_ADDR_B (CMD_AW'(15'h2AAA))
    ) u_match (
        .cmd_addr   (wr_addr[CMD_AW-1:0]),
        .cmd_code   (wr_data[7:0]),
        .at_key_a   (at_a),
        .at_key_b   (at_b),
        .is_unlk_a  (c_ua),
        .is_unlk_b  (c_ub),
        .is_prog    (c_prog),
        .is_ers_set (c_eset),
        .is_id_in   (c_idin),
        .is_id_out  (c_idout),
        .is_sect    (c_sect),
        .is_blk     (c_blk),
        .is_chip    (c_chip)
    );

    flash_prot_check #(
        .BLK_IDX_W  (BLK_IDX_W),
        .PROT_COUNT (PROT_COUNT)
    ) u_prot (
        .blk_idx (wr_addr[AW-1:BLK_LSB]),
        .wp_n    (wp_n),
        .locked  (locked)
    );

    flash_id_rom #(
        .AW (AW),
        .DW (DW)
    ) u_id (
        .id_mode  (ctl_q.id_mode),
        .rd_addr  (rd_addr),
        .id_data  (id_data),
        .id_valid (id_valid)
    );

    assign accept = wr_en && !busy;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.launch   = LN_NONE;
        ctl_d.skip_top = 1'b0;
        op_addr_d      = op_addr_q;
        op_data_d      = op_data_q;

        if (accept) begin
            ctl_d.seq = ST_IDLE;
            unique case (ctl_q.seq)
                ST_IDLE: begin
                    if (at_a && c_ua) ctl_d.seq = ST_UNLK1;
                end
                ST_UNLK1: begin
                    if (at_b && c_ub) ctl_d.seq = ST_UNLK2;
                end
                ST_UNLK2: begin
                    if (at_a && c_prog)       ctl_d.seq = ST_PROG;
                    else if (at_a && c_eset)  ctl_d.seq = ST_ERS1;
                    else if (at_a && c_idin)  ctl_d.id_mode = 1'b1;
                    else if (at_a && c_idout) ctl_d.id_mode = 1'b0;
                end
                ST_PROG: begin
                    if (!locked) begin
                        ctl_d.launch = LN_PROG;
                        op_addr_d    = wr_addr;
                        op_data_d    = wr_data;
                    end
                end
                ST_ERS1: begin
                    if (at_a && c_ua) ctl_d.seq = ST_ERS2;
                end
                ST_ERS2: begin
                    if (at_b && c_ub) ctl_d.seq = ST_ERS3;
                end
                ST_ERS3: begin
                    if (c_sect && !locked) begin
                        ctl_d.launch = LN_SECT;
                        op_addr_d    = {wr_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
                        op_data_d    = '0;
                    end else if (c_blk && !locked) begin
                        ctl_d.launch = LN_BLK;
                        op_addr_d    = {wr_addr[AW-1:BLK_LSB], {BLK_LSB{1'b0}}};
                        op_data_d    = '0;
                    end else if (c_chip && at_a) begin
                        ctl_d.launch   = LN_CHIP;
                        ctl_d.skip_top = !wp_n;
                        op_addr_d      = '0;
                        op_data_d      = '0;
                    end
                end
                default: ctl_d.seq = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '{seq: ST_IDLE, id_mode: 1'b0, launch: LN_NONE, skip_top: 1'b0};
            op_addr_q <= '0;
            op_data_q <= '0;
        end else begin
            ctl_q     <= ctl_d;
            op_addr_q <= op_addr_d;
            op_data_q <= op_data_d;
        end
    end

    assign id_mode       = ctl_q.id_mode;
    assign go_prog       = (ctl_q.launch == LN_PROG);
    assign go_sect_erase = (ctl_q.launch == LN_SECT);
    assign go_blk_erase  = (ctl_q.launch == LN_BLK);
    assign go_chip_erase = (ctl_q.launch == LN_CHIP);
    assign skip_top      = ctl_q.skip_top;
    assign op_addr       = op_addr_q;
    assign op_data       = op_data_q;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int unsigned AW         = 20,
    parameter int unsigned BLK_LSB    = 15,
    parameter int unsigned PROT_COUNT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          busy,
    input logic          wp_n,
    input logic          id_mode,
    input logic          id_valid,
    input logic          go_prog,
    input logic          go_sect_erase,
    input logic          go_blk_erase,
    input logic          go_chip_erase,
    input logic          skip_top,
    input logic [AW-1:0] op_addr
);
    localparam int unsigned NUM_BLK    = 1 << (AW - BLK_LSB);
    localparam int unsigned FIRST_PROT = NUM_BLK - PROT_COUNT;

    logic go_any;
    logic go_targeted;
    assign go_any      = go_prog | go_sect_erase | go_blk_erase | go_chip_erase;
    assign go_targeted = go_prog | go_sect_erase | go_blk_erase;

    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_prog, go_sect_erase, go_blk_erase, go_chip_erase}));

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go_any |=> !go_any);

    p_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go_any |-> ($past(wr_en) && !$past(busy)));

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !go_any);

    p_busy_id_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(id_mode));

    p_protect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_targeted && !$past(wp_n)) |-> (op_addr[AW-1:BLK_LSB] < FIRST_PROT));

    p_chip_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go_chip_erase |-> (skip_top == !$past(wp_n)));

    p_id_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> id_mode);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .AW         (AW),
    .BLK_LSB    (BLK_LSB),
    .PROT_COUNT (PROT_COUNT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .busy          (busy),
    .wp_n          (wp_n),
    .id_mode       (id_mode),
    .id_valid      (id_valid),
    .go_prog       (go_prog),
    .go_sect_erase (go_sect_erase),
    .go_blk_erase  (go_blk_erase),
    .go_chip_erase (go_chip_erase),
    .skip_top      (skip_top),
    .op_addr       (op_addr)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    localparam int K_PROG = 1, K_SECT = 2, K_BLK = 3, K_CHIP = 4;

    typedef struct packed {
        logic [2:0]  kind;
        logic [19:0] addr;
        logic [15:0] data;
        logic        skip;
    } exp_s;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        wp_n = 1'b1;
    logic [19:0] rd_addr = '0;
    logic        id_mode, id_valid;
    logic [15:0] id_data;
    logic        go_prog, go_sect_erase, go_blk_erase, go_chip_erase, skip_top;
    logic [19:0] op_addr;
    logic [15:0] op_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_s expq[$];

    always #4 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .wp_n(wp_n), .rd_addr(rd_addr),
        .id_mode(id_mode), .id_data(id_data), .id_valid(id_valid),
        .go_prog(go_prog), .go_sect_erase(go_sect_erase),
        .go_blk_erase(go_blk_erase), .go_chip_erase(go_chip_erase),
        .skip_top(skip_top), .op_addr(op_addr), .op_data(op_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock();
        wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
    endtask

    task automatic erase_pre();
        unlock();
        wr(20'h05555, 16'h0080);
        unlock();
    endtask

    task automatic expect_launch(input int k, input logic [19:0] a,
                                 input logic [15:0] d, input logic s);
        exp_s e;
        e.kind = 3'(k);
        e.addr = a;
        e.data = d;
        e.skip = s;
        expq.push_back(e);
    endtask

    // Monitor: compares every launch pulse against the scoreboard queue (R12 one-hot)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                int n;
                logic [2:0] k;
                n = int'(go_prog) + int'(go_sect_erase) + int'(go_blk_erase) + int'(go_chip_erase);
                k = go_prog ? 3'(K_PROG) : go_sect_erase ? 3'(K_SECT) :
                    go_blk_erase ? 3'(K_BLK) : go_chip_erase ? 3'(K_CHIP) : 3'd0;
                if (n > 1) check(1'b0, "R12 multiple launches", 32'(n), 32'd1);
                if (n == 1) begin
                    if (expq.size() == 0) begin
                        check(1'b0, "R12/R1/R8/R9/R10 unexpected launch", {29'd0, k}, 32'd0);
                    end else begin
                        exp_s e;
                        e = expq.pop_front();
                        check(k == e.kind, "R2/R3/R4/R5 launch kind", {29'd0, k}, {29'd0, e.kind});
                        check(op_addr == e.addr, "R2/R3/R4/R5 launch address", {12'd0, op_addr}, {12'd0, e.addr});
                        if (k == 3'(K_PROG))
                            check(op_data == e.data, "R2 program data", {16'd0, op_data}, {16'd0, e.data});
                        if (k == 3'(K_CHIP))
                            check(skip_top == e.skip, "R5 skip_top", {31'd0, skip_top}, {31'd0, e.skip});
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!go_prog && !go_sect_erase && !go_blk_erase && !go_chip_erase,
              "R11 launches low in reset", 32'(go_prog), 32'd0);
        check(id_mode == 1'b0, "R11 id_mode clear in reset", 32'(id_mode), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 plain program
        unlock();
        wr(20'h05555, 16'h00A0);
        expect_launch(K_PROG, 20'h12345, 16'hBEEF, 1'b0);
        wr(20'h12345, 16'hBEEF);

        // R7 upper address and data bits ignored
        wr(20'hF5555, 16'h3CAA);
        wr(20'hA2AAA, 16'hFF55);
        wr(20'h35555, 16'h77A0);
        expect_launch(K_PROG, 20'h00777, 16'h1234, 1'b0);
        wr(20'h00777, 16'h1234);

        // R3 sector erase with alignment
        erase_pre();
        expect_launch(K_SECT, 20'h34400, 16'h0000, 1'b0);
        wr(20'h34567, 16'h0030);

        // R4 block erase with alignment
        erase_pre();
        expect_launch(K_BLK, 20'h48000, 16'h0000, 1'b0);
        wr(20'h4ABCD, 16'h0050);

        // R5 chip erase, protect asserted then released
        wp_n = 1'b0;
        erase_pre();
        expect_launch(K_CHIP, 20'h00000, 16'h0000, 1'b1);
        wr(20'h05555, 16'h0010);
        wp_n = 1'b1;
        erase_pre();
        expect_launch(K_CHIP, 20'h00000, 16'h0000, 1'b0);
        wr(20'h05555, 16'h0010);

        // R6 identification mode
        unlock();
        wr(20'h05555, 16'h0090);
        check(id_mode == 1'b1, "R6 id entry", 32'(id_mode), 32'd1);
        rd_addr = 20'h00000; #1;
        check(id_valid && id_data == 16'h00BF, "R6 word0", {16'd0, id_data}, 32'h00BF);
        rd_addr = 20'h00001; #1;
        check(id_valid && id_data == 16'h2762, "R6 word1", {16'd0, id_data}, 32'h2762);
        rd_addr = 20'h00002; #1;
        check(!id_valid && id_data == 16'h0, "R6 other address", {16'd0, id_data}, 32'h0);

        // R9 exit ignored while busy
        busy = 1'b1;
        unlock();
        wr(20'h05555, 16'h00F0);
        check(id_mode == 1'b1, "R9 id exit ignored while busy", 32'(id_mode), 32'd1);
        busy = 1'b0;
        unlock();
        wr(20'h05555, 16'h00F0);
        check(id_mode == 1'b0, "R6 id exit", 32'(id_mode), 32'd0);
        rd_addr = 20'h00000; #1;
        check(!id_valid, "R6 no identifier after exit", 32'(id_valid), 32'd0);

        // R9 busy-blocked write keeps program armed; next write completes it
        unlock();
        wr(20'h05555, 16'h00A0);
        busy = 1'b1;
        wr(20'h11111, 16'h1111);
        busy = 1'b0;
        expect_launch(K_PROG, 20'h22222, 16'h2222, 1'b0);
        wr(20'h22222, 16'h2222);

        // R8 wrong step aborts; the next write is not a fresh start
        wr(20'h05555, 16'h00AA);
        wr(20'h05555, 16'h0055);
        wr(20'h02AAA, 16'h0055);
        wr(20'h05555, 16'h00A0);
        wr(20'h01000, 16'h4444);
        check(expq.size() == 0, "R8 aborted sequence pending", 32'(expq.size()), 32'd0);
        // R8 wrong erase step aborts
        unlock();
        wr(20'h05555, 16'h0080);
        wr(20'h02AAA, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
        wr(20'h34567, 16'h0030);

        // R1 setup code with no unlock
        wr(20'h05555, 16'h00A0);
        wr(20'h03000, 16'h5555);
        wr(20'h05555, 16'h0090);
        check(id_mode == 1'b0, "R1 no id entry without unlock", 32'(id_mode), 32'd0);

        // R10 protection filtering
        wp_n = 1'b0;
        unlock();
        wr(20'h05555, 16'h00A0);
        wr(20'hF0000, 16'h6666);
        erase_pre();
        wr(20'hE8000, 16'h0050);
        erase_pre();
        wr(20'hE0400, 16'h0030);
        unlock();
        wr(20'h05555, 16'h00A0);
        expect_launch(K_PROG, 20'hD0000, 16'h7777, 1'b0);
        wr(20'hD0000, 16'h7777);
        wp_n = 1'b1;
        unlock();
        wr(20'h05555, 16'h00A0);
        expect_launch(K_PROG, 20'hF0000, 16'h8888, 1'b0);
        wr(20'hF0000, 16'h8888);

        // R11 reset mid-sequence clears id mode and armed program
        unlock();
        wr(20'h05555, 16'h0090);
        unlock();
        wr(20'h05555, 16'h00A0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(id_mode == 1'b0, "R11 reset clears id_mode", 32'(id_mode), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(20'h09999, 16'h9999);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R2/R3/R4/R5 missing launch", 32'(expq.size()), 32'd0);
        finish_run();
    end

endmodule